// File: doc/BRIEF.md
# Dual-Exposure Rolling-Shutter Sequencer

This block is the row-timing controller for a rolling-shutter pixel array that captures high-dynamic-range images from two exposures. Each acquisition cycle has two frames. Frame 1 is reset row by row and read after a long exposure. Frame 2 is reset on each row right after that row's frame-1 read, and it is read after a short exposure. All four scans share one row-address bus and one column readout path. They are interleaved inside a fixed row slot, so no scan waits for another.

Each row slot has four quarters of `NGROUPS` clocks each, always in this order:
1. quarter 0: frame-1 read
2. quarter 1: frame-2 read
3. quarter 2: frame-1 reset
4. quarter 3: frame-2 reset

A quarter with a due read enables the column current sources and steps through the column groups, one per clock. Every read carries a frame flag and a start-of-frame flag. The block also reports how many frame-1 rows a downstream fusion buffer must hold. A mode input selects single-exposure operation, which has only frame 1.

Exposure lengths are given in row slots. They are captured when a cycle starts. A cycle starts on a clock edge where `run` is high and the block is idle or finishing a cycle, so cycles run back to back while `run` stays high.

Top module: `dx_seq`

## Requirements
- R1: After reset, and while idle before any cycle, all strobes, `rd_frame`, `rd_sof` and `col_en` are 0, and `row_addr`, `col_grp` and `fuse_rows` are 0.
- R2: In slot t of a cycle (slots counted from 0 at cycle start), the frame-1 reset of row t is issued for t < ROWS. It is a one-clock `rst_stb` on the first clock of quarter 2.
- R3: The frame-1 read of row r is issued in slot r+L. It is a one-clock `rd_stb` on the first clock of quarter 0, with `rd_frame`=0.
- R4: In dual mode, the frame-2 reset of row r is issued in slot r+L on the first clock of quarter 3. This is the same slot as that row's frame-1 read.
- R5: In dual mode, the frame-2 read of row r is issued in slot r+L+S on the first clock of quarter 1, with `rd_frame`=1.
- R6: Reads occur only in the first half of a slot (quarters 0 and 1) and resets only in the second half (quarters 2 and 3). The two strobes are never high together.
- R7: `col_en` is 1 for exactly the NGROUPS clocks of a quarter that holds a read. During those clocks `col_grp` counts 0, 1, …, NGROUPS-1. Otherwise `col_en` is 0 and `col_grp` is 0.
- R8: `rd_sof` is 1 only together with a `rd_stb` for row 0. `row_addr` is 0 whenever neither strobe is high.
- R9: In single mode (`dual_mode`=0), no frame-2 reset or read occurs and `fuse_rows` is 0.
- R10: In dual mode, `fuse_rows` equals the effective short exposure S from the first clock of the cycle.
- R11: The effective exposures are S = max(1, `exp_short`) and L = max(S, `exp_long`).
- R12: Mode and exposure inputs are sampled only on the clock edge that starts a cycle. Changes during a cycle have no effect on that cycle.
- R13: A cycle lasts ROWS+L+S slots in dual mode and ROWS+L in single mode. If `run` is 1 at its last clock, the next cycle starts on the following clock. Otherwise the block goes idle, with no strobes and `col_en` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Start or continue acquisition cycles |
| dual_mode | input | 1 | 1 selects two exposures, 0 selects one |
| exp_long | input | EXP_W | Long exposure in row slots |
| exp_short | input | EXP_W | Short exposure in row slots |
| row_addr | output | ROW_W | Row addressed by the current strobe |
| rst_stb | output | 1 | Row reset strobe |
| rd_stb | output | 1 | Row read strobe |
| rd_frame | output | 1 | Frame of the current read (0 long, 1 short) |
| rd_sof | output | 1 | Read of row 0 (start of frame) |
| col_en | output | 1 | Column current source enable |
| col_grp | output | GRP_W | Column group being converted |
| fuse_rows | output | EXP_W | Frame-1 rows the fusion buffer must hold |

## Verification
The bench compares every output on every clock of whole cycles against a slot/quarter model derived from the requirements. It uses configurations that pull the scans apart in distinct ways:
- a long exposure shorter than the frame, so reset and read scans overlap;
- a long exposure longer than the frame, so the scans are disjoint;
- equal exposures, where frame-2 reads run right behind frame-1 reads;
- zero and inverted exposure inputs, which exercise clamping;
- single mode.

In each cycle the inputs are changed after start, so any leak of live inputs shows up as a shifted strobe. Directed runs cover the reset state, two back-to-back cycles under a held `run`, and the return to idle.

// File: rtl/dxs_pkg.sv
package dxs_pkg;

  // Quarters of a row slot: reads in the first half, resets in the second.
  typedef enum logic [1:0] {
    PH_RD_F1 = 2'd0,
    PH_RD_F2 = 2'd1,
    PH_RS_F1 = 2'd2,
    PH_RS_F2 = 2'd3
  } phase_e;

  // Short exposure is at least one slot.
  function automatic int unsigned eff_short(int unsigned s);
    return (s == 0) ? 1 : s;
  endfunction

  // Long exposure is never below the effective short one.
  function automatic int unsigned eff_long(int unsigned l, int unsigned s);
    int unsigned es;
    es = eff_short(s);
    return (l < es) ? es : l;
  endfunction

  // Slots in one acquisition cycle.
  function automatic int unsigned cyc_slots(int unsigned rows, int unsigned l,
                                            int unsigned s, logic dual);
    return dual ? rows + l + s : rows + l;
  endfunction

endpackage

// File: rtl/dxs_timebase.sv
module dxs_timebase
  import dxs_pkg::*;
#(
  parameter int NGROUPS = 22,
  parameter int T_W     = 12,
  localparam int GRP_W  = $clog2(NGROUPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [T_W-1:0]   cyc_len,
  output logic             active,
  output logic             load,
  output logic [T_W-1:0]   slot,
  output phase_e           phase,
  output logic [GRP_W-1:0] pclk
);

  logic last_pc, slot_end, cyc_end;

  assign last_pc  = (pclk == GRP_W'(NGROUPS - 1));
  assign slot_end = last_pc && (phase == PH_RS_F2);
  assign cyc_end  = active && slot_end && (slot == cyc_len - T_W'(1));
  assign load     = run && (!active || cyc_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      pclk   <= '0;
      phase  <= PH_RD_F1;
      slot   <= '0;
    end else if (load) begin
      active <= 1'b1;
      pclk   <= '0;
      phase  <= PH_RD_F1;
      slot   <= '0;
    end else if (cyc_end) begin
      active <= 1'b0;
      pclk   <= '0;
      phase  <= PH_RD_F1;
      slot   <= '0;
    end else if (active) begin
      if (last_pc) begin
        pclk  <= '0;
        phase <= phase_e'(phase + 2'd1);
        if (slot_end) slot <= slot + T_W'(1);
      end else begin
        pclk <= pclk + GRP_W'(1);
      end
    end
  end

endmodule

// File: rtl/dxs_evdec.sv
module dxs_evdec
  import dxs_pkg::*;
#(
  parameter int ROWS   = 288,
  parameter int T_W    = 12,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic             active,
  input  logic             dual,
  input  logic [T_W-1:0]   lat_long,
  input  logic [T_W-1:0]   lat_short,
  input  logic [T_W-1:0]   slot,
  input  phase_e           phase,
  output logic             ev_due,
  output logic             ev_is_read,
  output logic             ev_frame,
  output logic [ROW_W-1:0] ev_row
);

  localparam logic [T_W-1:0] TROWS = T_W'(ROWS);

  logic [T_W-1:0] d1, d2;
  logic           f1_rd, f2_rd, f1_rs, f2_rs;

  assign d1    = slot - lat_long;
  assign d2    = slot - lat_long - lat_short;
  assign f1_rd = (slot >= lat_long) && (d1 < TROWS);
  assign f2_rd = dual && (slot >= lat_long + lat_short) && (d2 < TROWS);
  assign f1_rs = (slot < TROWS);
  assign f2_rs = dual && f1_rd;

  always_comb begin
    ev_due     = 1'b0;
    ev_is_read = 1'b0;
    ev_frame   = 1'b0;
    ev_row     = '0;
    unique case (phase)
      PH_RD_F1: begin ev_due = f1_rd; ev_is_read = 1'b1; ev_row = ROW_W'(d1); end
      PH_RD_F2: begin ev_due = f2_rd; ev_is_read = 1'b1; ev_frame = 1'b1; ev_row = ROW_W'(d2); end
      PH_RS_F1: begin ev_due = f1_rs; ev_row = ROW_W'(slot); end
      PH_RS_F2: begin ev_due = f2_rs; ev_frame = 1'b1; ev_row = ROW_W'(d1); end
      default:  ;
    endcase
    ev_due = ev_due && active;
  end

endmodule

// File: rtl/dx_seq.sv
module dx_seq
  import dxs_pkg::*;
#(
  parameter int ROWS    = 288,
  parameter int NGROUPS = 22,
  parameter int EXP_W   = 10,
  localparam int ROW_W  = $clog2(ROWS),
  localparam int GRP_W  = $clog2(NGROUPS),
  localparam int T_W    = ((ROW_W > EXP_W) ? ROW_W : EXP_W) + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             dual_mode,
  input  logic [EXP_W-1:0] exp_long,
  input  logic [EXP_W-1:0] exp_short,
  output logic [ROW_W-1:0] row_addr,
  output logic             rst_stb,
  output logic             rd_stb,
  output logic             rd_frame,
  output logic             rd_sof,
  output logic             col_en,
  output logic [GRP_W-1:0] col_grp,
  output logic [EXP_W-1:0] fuse_rows
);

  logic             active_w, load_w;
  logic [T_W-1:0]   slot_w, cyc_len;
  phase_e           phase_w;
  logic [1:0]       ph_w;
  logic [GRP_W-1:0] pclk_w;
  logic             lat_dual;
  logic [T_W-1:0]   lat_long, lat_short;
  logic             ev_due, ev_is_read, ev_frame, first_clk;
  logic [ROW_W-1:0] ev_row;

  // Configuration captured only at a cycle start.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_dual  <= 1'b0;
      lat_long  <= '0;
      lat_short <= '0;
    end else if (load_w) begin
      lat_dual  <= dual_mode;
      lat_short <= T_W'(eff_short(32'(exp_short)));
      lat_long  <= T_W'(eff_long(32'(exp_long), 32'(exp_short)));
    end
  end

  assign cyc_len = T_W'(cyc_slots(ROWS, 32'(lat_long), 32'(lat_short), lat_dual));

  dxs_timebase #(.NGROUPS(NGROUPS), .T_W(T_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .run(run), .cyc_len(cyc_len),
    .active(active_w), .load(load_w), .slot(slot_w), .phase(phase_w), .pclk(pclk_w)
  );

  dxs_evdec #(.ROWS(ROWS), .T_W(T_W)) u_dec (
    .active(active_w), .dual(lat_dual), .lat_long(lat_long), .lat_short(lat_short),
    .slot(slot_w), .phase(phase_w), .ev_due(ev_due), .ev_is_read(ev_is_read),
    .ev_frame(ev_frame), .ev_row(ev_row)
  );

  assign ph_w      = phase_w;
  assign first_clk = (pclk_w == '0);
  assign rd_stb    = ev_due && ev_is_read && first_clk;
  assign rst_stb   = ev_due && !ev_is_read && first_clk;
  assign row_addr  = (rd_stb || rst_stb) ? ev_row : '0;
  assign rd_frame  = rd_stb && ev_frame;
  assign rd_sof    = rd_stb && (ev_row == '0);
  assign col_en    = ev_due && ev_is_read;
  assign col_grp   = col_en ? pclk_w : '0;
  assign fuse_rows = lat_dual ? EXP_W'(lat_short) : '0;

endmodule

// File: rtl/dxs_seq_chk.sv
module dxs_seq_chk #(
  parameter int ROWS  = 288,
  parameter int ROW_W = 9,
  parameter int GRP_W = 5,
  parameter int EXP_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_stb,
  input logic             rst_stb,
  input logic             rd_frame,
  input logic             rd_sof,
  input logic             col_en,
  input logic [ROW_W-1:0] row_addr,
  input logic [GRP_W-1:0] col_grp,
  input logic [EXP_W-1:0] fuse_rows,
  input logic [1:0]       phase,
  input logic             load
);

  AST_RD_FIRST_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |-> phase < 2'd2); // R6
  AST_RST_SECOND_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    rst_stb |-> phase >= 2'd2); // R6
  AST_STB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb && rst_stb)); // R6
  AST_ROW_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb || rst_stb) |-> 32'(row_addr) < ROWS); // R2
  AST_SOF_ROW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sof |-> (rd_stb && row_addr == '0)); // R8
  AST_SHORT_READ_DUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && rd_frame) |-> fuse_rows != '0); // R9
  AST_READ_ENABLES_COL: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |-> (col_en && col_grp == '0)); // R7
  AST_COL_GROUP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (col_en && $past(col_en) && !rd_stb) |-> col_grp == $past(col_grp) + GRP_W'(1)); // R7
  AST_FUSE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(fuse_rows)); // R12

endmodule

bind dx_seq dxs_seq_chk #(.ROWS(ROWS), .ROW_W(ROW_W), .GRP_W(GRP_W), .EXP_W(EXP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rst_stb(rst_stb), .rd_frame(rd_frame),
  .rd_sof(rd_sof), .col_en(col_en), .row_addr(row_addr), .col_grp(col_grp),
  .fuse_rows(fuse_rows), .phase(ph_w), .load(load_w)
);

// File: tb/tb_dx_seq.sv
module tb_dx_seq;

  localparam int N  = 6;
  localparam int G  = 3;
  localparam int EW = 6;
  localparam int RW = $clog2(N);
  localparam int GW = $clog2(G);
  localparam int OW = 5 + GW + RW + EW;

  // Vector table: mode, long input, short input.
  localparam int NV = 6;
  localparam int VD [NV] = '{1, 1, 0, 1, 1, 1};
  localparam int VL [NV] = '{4, 8, 5, 2, 1, 2};
  localparam int VS [NV] = '{1, 3, 2, 2, 0, 5};

  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0, dual_mode = 1'b0;
  logic [EW-1:0] exp_long = '0, exp_short = '0;
  logic [RW-1:0] row_addr;
  logic rst_stb, rd_stb, rd_frame, rd_sof, col_en;
  logic [GW-1:0] col_grp;
  logic [EW-1:0] fuse_rows;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  dx_seq #(.ROWS(N), .NGROUPS(G), .EXP_W(EW)) dut (
    .clk(clk), .rst_n(rst_n), .run(run), .dual_mode(dual_mode),
    .exp_long(exp_long), .exp_short(exp_short), .row_addr(row_addr),
    .rst_stb(rst_stb), .rd_stb(rd_stb), .rd_frame(rd_frame), .rd_sof(rd_sof),
    .col_en(col_en), .col_grp(col_grp), .fuse_rows(fuse_rows)
  );

  // R11: bench view of the effective exposures.
  function automatic int short_of(int s); return (s < 1) ? 1 : s; endfunction
  function automatic int long_of(int l, int s);
    return (l < short_of(s)) ? short_of(s) : l;
  endfunction

  function automatic logic [OW-1:0] actual();
    return {rd_stb, rst_stb, rd_frame, rd_sof, col_en, col_grp, row_addr, fuse_rows};
  endfunction

  task automatic compare(string tag, logic [OW-1:0] exp_v);
    n_chk++;
    if (actual() !== exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, actual(), exp_v, $time);
    end
  endtask

  // Expected outputs k clocks into a cycle (k=0: first clock after the start edge).
  task automatic chk_clk(int k, int d, int le, int se);
    int t = k / (4 * G);
    int ph = (k / G) % 4;
    int pc = k % G;
    logic e_rd = 1'b0, e_rs = 1'b0, e_fr = 1'b0;
    int row = 0;
    string tag;
    // Row r: long reset in slot r, long read and short reset in slot r+le, short read in slot r+le+se.
    if (ph == 0 && t - le >= 0 && t - le < N)             begin e_rd = 1; row = t - le; end
    if (ph == 1 && d == 1 && t - le - se >= 0 && t - le - se < N) begin e_rd = 1; e_fr = 1; row = t - le - se; end
    if (ph == 2 && t < N)                                 begin e_rs = 1; row = t; end
    if (ph == 3 && d == 1 && t - le >= 0 && t - le < N)   begin e_rs = 1; row = t - le; end
    case (ph)
      0: tag = "R3";
      1: tag = (d == 1) ? "R5" : "R9";
      2: tag = "R2";
      default: tag = (d == 1) ? "R4" : "R9";
    endcase
    if ((actual() & {{(OW-EW){1'b0}}, {EW{1'b1}}}) !== OW'(d == 1 ? se : 0)) tag = "R10";
    if (col_en !== e_rd) tag = "R7";
    compare(tag, {e_rd && pc == 0, e_rs && pc == 0, e_fr && pc == 0,
                  e_rd && pc == 0 && row == 0, e_rd, GW'(e_rd ? pc : 0),
                  RW'((pc == 0 && (e_rd || e_rs)) ? row : 0), EW'(d == 1 ? se : 0)});
  endtask

  // R13: after a cycle with run low, nothing is strobed; fusion depth is kept.
  task automatic chk_idle(int d, int se);
    for (int i = 0; i < 4 * G; i++) begin
      compare("R13", {5'b0, GW'(0), RW'(0), EW'(d == 1 ? se : 0)});
      @(negedge clk);
    end
  endtask

  // One cycle; inputs are scrambled after the start (R12).
  task automatic one_cycle(int d, int l, int s);
    int le = long_of(l, s);
    int se = short_of(s);
    int total = (d == 1 ? N + le + se : N + le) * 4 * G;
    @(negedge clk);
    dual_mode = d[0]; exp_long = EW'(l); exp_short = EW'(s); run = 1'b1;
    @(negedge clk);
    run = 1'b0;
    for (int k = 0; k < total; k++) begin
      if (k == 5) begin dual_mode = ~dual_mode; exp_long = EW'(l + 7); exp_short = EW'(0); end
      chk_clk(k, d, le, se);
      @(negedge clk);
    end
    chk_idle(d, se);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R13 watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1", '0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      compare("R1", '0);   // R1: idle after reset, run low
    end

    // Table walk: overlap (4,1), disjoint (8,3), single mode R9 (5,2),
    // equal exposures (2,2), clamp R11 (1,0) -> L=S=1, (2,5) -> L=S=5.
    for (int v = 0; v < NV; v++) one_cycle(VD[v], VL[v], VS[v]);

    // R13: two back-to-back cycles while run stays high.
    begin
      int le = long_of(3, 2);
      int se = short_of(2);
      int total = (N + le + se) * 4 * G;
      @(negedge clk);
      dual_mode = 1'b1; exp_long = EW'(3); exp_short = EW'(2); run = 1'b1;
      @(negedge clk);
      for (int k = 0; k < 2 * total; k++) begin
        if (k == total) run = 1'b0;
        chk_clk(k % total, 1, le, se);
        @(negedge clk);
      end
      chk_idle(1, se);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule